// File: doc/BRIEF.md
# Auto-Detecting Keyboard Frame Receiver

This block receives scan bytes from a keyboard that drives a clock line and a data line. It samples the data line on every falling edge of the keyboard clock. It works out, while the frame is still arriving, which of three frame formats the keyboard uses. The bits shift into a 16-bit register that starts with a single marker bit at the top. As bits arrive the marker walks downward. The marker's position, together with the bits just above it, tells the block whether the frame is still running, has finished, or cannot be valid.

Some bit patterns could either end a short frame or belong to a longer one. For these, the receiver waits a bounded number of system cycles for one more clock edge. If no edge comes, the frame is the short one. The detected format is remembered, and later ambiguous frames resolve at once. Each finished frame produces a one-cycle byte strobe with the byte and the format code. Each faulty frame produces a one-cycle error strobe with an error code. On an error, and while the downstream buffer reports full, the block asks the pad logic to hold the keyboard clock low. This stops the keyboard from sending.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset `byte_valid_o` and `err_valid_o` are 0, `proto_o` is 0 (no format known) and `kb_clk_hold_o` is 0.
- R2: An 11-edge frame (start bit 0, data bits LSB first, parity bit, stop bit 1) whose data plus parity holds an odd number of ones yields a byte strobe with that byte and `proto_o` = 1.
- R3: The same frame with a stop bit of 0 is accepted, and `proto_o` = 2.
- R4: In an 11-edge frame, an even count of ones over data plus parity gives `err_code_o` = 1. The single pattern data 0xAA, parity 0, stop 1 gives `err_code_o` = 2 instead.
- R5: A 10-edge frame (0, 1, then 8 data bits LSB first) received with no format known completes only after WAIT_CYC cycles without an edge, with `proto_o` = 3. Once format 3 is known, the same frame completes right after its last edge.
- R6: A 9-edge frame (1, then 8 data bits LSB first) received with no format known completes after WAIT_CYC idle cycles, with `proto_o` = 4. Once format 4 is known, it completes right after its last edge.
- R7: A 10-edge frame that begins 1, 1 completes with the byte taken from its last 8 bits (LSB first), `proto_o` = 5, and no error.
- R8: A 10-edge frame that begins 1, 0 and is not resolved earlier gives `err_code_o` = 3 and sets `proto_o` back to 0.
- R9: Inside a frame, a gap of TIMEOUT_CYC cycles without a falling edge gives `err_code_o` = 4 and leaves `proto_o` unchanged.
- R10: After any error, `kb_clk_hold_o` stays 1 and keyboard edges are ignored until a `resume_i` pulse. Reception then restarts from an empty frame.
- R11: While `buf_full_i` is 1, `kb_clk_hold_o` is 1 and keyboard edges are ignored. After it drops, frames are received normally.
- R12: When a format other than the one an ambiguous pattern would finish is already known, that pattern is treated as the middle of a longer frame, with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kb_clk_i | input | 1 | Keyboard clock line as seen at the pad |
| kb_data_i | input | 1 | Keyboard data line as seen at the pad |
| buf_full_i | input | 1 | Downstream byte buffer is full |
| resume_i | input | 1 | One-cycle pulse that releases the inhibit left by an error |
| kb_clk_hold_o | output | 1 | Request to pull the keyboard clock low |
| byte_valid_o | output | 1 | One-cycle strobe: a byte is complete |
| byte_o | output | 8 | Received byte, held until the next strobe |
| proto_o | output | 3 | Remembered format: 0 none, 1 AT, 2 AT with low stop, 3 IBM XT, 4 clone XT, 5 XT error |
| err_valid_o | output | 1 | One-cycle strobe: a frame failed |
| err_code_o | output | 3 | 1 parity, 2 0xAA with bad parity, 3 illegal pattern, 4 timeout |

## Verification
The bench builds the receiver with WAIT_CYC = 40 and TIMEOUT_CYC = 300, with keyboard clock edges 16 system cycles apart. With these values, both the resolution of an ambiguous pattern and the inter-edge timeout happen within a few hundred cycles. The bench can therefore tell a waited completion from an immediate one by sampling before and after the window. The short windows also leave room to sweep every one of the 256 data bytes through an AT frame, alongside the stop, parity, format-memory and inhibit corner cases.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  typedef enum logic [2:0] {
    PROTO_NONE       = 3'd0,
    PROTO_AT         = 3'd1,
    PROTO_AT_LOWSTOP = 3'd2,
    PROTO_XT_IBM     = 3'd3,
    PROTO_XT_CLONE   = 3'd4,
    PROTO_XT_ERR     = 3'd5
  } kbd_proto_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_PARITY    = 3'd1,
    ERR_PARITY_AA = 3'd2,
    ERR_ILLEGAL   = 3'd3,
    ERR_TIMEOUT   = 3'd4
  } kbd_err_e;

  // Meaning of the low byte of the shifted register
  typedef enum logic [2:0] {
    CLS_MIDWAY    = 3'd0,
    CLS_AMBIG_ONE = 3'd1,  // short single-start frame done, or longer frame
    CLS_AMBIG_TWO = 3'd2,  // double-start frame done, or AT with b0 = 1
    CLS_XT_ERR    = 3'd3,
    CLS_AT_DONE   = 3'd4,
    CLS_ILLEGAL   = 3'd5
  } kbd_cls_e;

  localparam int unsigned FRAME_W = 16;
  localparam logic [FRAME_W-1:0] SHIFT_IDLE = 16'h8000;
  localparam logic [FRAME_W-1:0] AA_BADPAR  = 16'hAA90;

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_n [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_n[g] = line_i;
      end else begin : g_rest
        assign stage_n[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_n[g];
      end
    end
  endgenerate

  assign line_o = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_gap_timer.sv
module kbd_gap_timer #(
  parameter int unsigned LIMIT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign hit_o   = run_i && at_last;

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)                 cnt_n = '0;
    else if (run_i && !at_last) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // Counter never passes its limit (R5, R9 windows)
  p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // A running, uncleared count advances by exactly one (R5)
  p_count_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/kbd_frame_classify.sv
module kbd_frame_classify
  import kbd_rx_pkg::*;
(
  input  logic [FRAME_W-1:0] shift_i,
  output kbd_cls_e           cls_o,
  output logic [7:0]         at_byte_o,
  output logic               at_par_ok_o,
  output logic               at_stop_o,
  output logic               aa_hit_o
);

  always_comb begin
    unique case (shift_i[7:0])
      8'h00, 8'h80, 8'h40, 8'h20: cls_o = CLS_MIDWAY;
      8'hC0:                      cls_o = CLS_AMBIG_ONE;
      8'hA0:                      cls_o = CLS_AMBIG_TWO;
      8'hE0:                      cls_o = CLS_XT_ERR;
      8'h10, 8'h90, 8'h50, 8'hD0: cls_o = CLS_AT_DONE;
      default:                    cls_o = CLS_ILLEGAL;
    endcase
  end

  // AT layout once the marker sits at bit 4: stop, parity, b7..b0 down to bit 6
  assign at_byte_o   = shift_i[13:6];
  assign at_par_ok_o = ^shift_i[14:6];
  assign at_stop_o   = shift_i[15];
  assign aa_hit_o    = (shift_i == AA_BADPAR);

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int unsigned WAIT_CYC    = 25000,
  parameter int unsigned TIMEOUT_CYC = 1250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_data_i,
  input  logic       buf_full_i,
  input  logic       resume_i,
  output logic       kb_clk_hold_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic [2:0] proto_o,
  output logic       err_valid_o,
  output logic [2:0] err_code_o
);

  // ---------------- reset release ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // ---------------- line sync and edge ----------------
  logic [1:0] lines_s;
  logic       kbc_s, kbd_s, kbc_prev_q, kbc_fall;

  kbd_line_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .line_i({kb_clk_i, kb_data_i}),
    .line_o(lines_s)
  );

  assign kbc_s = lines_s[1];
  assign kbd_s = lines_s[0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) kbc_prev_q <= 1'b1;
    else         kbc_prev_q <= kbc_s;
  end
  assign kbc_fall = kbc_prev_q && !kbc_s;

  // ---------------- state ----------------
  logic [FRAME_W-1:0] sr_q, sr_n, shift_nx;
  logic               pend_q, pend_n;
  kbd_proto_e         pend_proto_q, pend_proto_n;
  kbd_proto_e         proto_q, proto_n;
  logic               err_hold_q, err_hold_n;
  logic [7:0]         byte_q, byte_n;
  logic               bvld_q, bvld_n;
  kbd_err_e           err_q, err_n;
  logic               evld_q, evld_n;

  logic     inhibit, edge_take, mid_frame;
  logic     wait_clr, wait_hit, gap_clr, gap_hit;
  kbd_cls_e cls;
  logic [7:0] at_byte;
  logic     at_par_ok, at_stop, aa_hit;

  assign inhibit   = err_hold_q || buf_full_i;
  assign edge_take = kbc_fall && !inhibit;
  assign mid_frame = (sr_q != SHIFT_IDLE);
  assign shift_nx  = {kbd_s, sr_q[FRAME_W-1:1]};

  kbd_frame_classify u_cls (
    .shift_i    (shift_nx),
    .cls_o      (cls),
    .at_byte_o  (at_byte),
    .at_par_ok_o(at_par_ok),
    .at_stop_o  (at_stop),
    .aa_hit_o   (aa_hit)
  );

  // ---------------- timers ----------------
  assign wait_clr = !pend_q || edge_take;
  assign gap_clr  = edge_take || inhibit || !mid_frame;

  kbd_gap_timer #(.LIMIT(WAIT_CYC)) u_wait (
    .clk  (clk),
    .rst_n(rst_sn),
    .clr_i(wait_clr),
    .run_i(pend_q),
    .hit_o(wait_hit)
  );

  kbd_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_gap (
    .clk  (clk),
    .rst_n(rst_sn),
    .clr_i(gap_clr),
    .run_i(mid_frame),
    .hit_o(gap_hit)
  );

  // ---------------- next state ----------------
  always_comb begin
    sr_n         = sr_q;
    pend_n       = pend_q;
    pend_proto_n = pend_proto_q;
    proto_n      = proto_q;
    err_hold_n   = err_hold_q;
    byte_n       = byte_q;
    bvld_n       = 1'b0;
    err_n        = err_q;
    evld_n       = 1'b0;

    if (resume_i) err_hold_n = 1'b0;

    if (inhibit) begin
      sr_n   = SHIFT_IDLE;
      pend_n = 1'b0;
    end else if (edge_take) begin
      pend_n = 1'b0;
      sr_n   = shift_nx;
      unique case (cls)
        CLS_MIDWAY: begin
        end
        CLS_AMBIG_ONE: begin
          if (proto_q == PROTO_NONE) begin
            pend_n       = 1'b1;
            pend_proto_n = PROTO_XT_CLONE;
          end else if (proto_q == PROTO_XT_CLONE) begin
            sr_n   = SHIFT_IDLE;
            byte_n = shift_nx[15:8];
            bvld_n = 1'b1;
          end
        end
        CLS_AMBIG_TWO: begin
          if (proto_q == PROTO_NONE) begin
            pend_n       = 1'b1;
            pend_proto_n = PROTO_XT_IBM;
          end else if (proto_q == PROTO_XT_IBM) begin
            sr_n   = SHIFT_IDLE;
            byte_n = shift_nx[15:8];
            bvld_n = 1'b1;
          end
        end
        CLS_XT_ERR: begin
          sr_n    = SHIFT_IDLE;
          byte_n  = shift_nx[15:8];
          bvld_n  = 1'b1;
          proto_n = PROTO_XT_ERR;
        end
        CLS_AT_DONE: begin
          sr_n = SHIFT_IDLE;
          if (aa_hit) begin
            err_n      = ERR_PARITY_AA;
            evld_n     = 1'b1;
            err_hold_n = 1'b1;
          end else if (!at_par_ok) begin
            err_n      = ERR_PARITY;
            evld_n     = 1'b1;
            err_hold_n = 1'b1;
          end else begin
            byte_n  = at_byte;
            bvld_n  = 1'b1;
            proto_n = at_stop ? PROTO_AT : PROTO_AT_LOWSTOP;
          end
        end
        default: begin
          sr_n       = SHIFT_IDLE;
          proto_n    = PROTO_NONE;
          err_n      = ERR_ILLEGAL;
          evld_n     = 1'b1;
          err_hold_n = 1'b1;
        end
      endcase
    end else if (pend_q && wait_hit) begin
      sr_n    = SHIFT_IDLE;
      pend_n  = 1'b0;
      byte_n  = sr_q[15:8];
      bvld_n  = 1'b1;
      proto_n = pend_proto_q;
    end else if (gap_hit) begin
      sr_n       = SHIFT_IDLE;
      pend_n     = 1'b0;
      err_n      = ERR_TIMEOUT;
      evld_n     = 1'b1;
      err_hold_n = 1'b1;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sr_q         <= SHIFT_IDLE;
      pend_q       <= 1'b0;
      pend_proto_q <= PROTO_NONE;
      proto_q      <= PROTO_NONE;
      err_hold_q   <= 1'b0;
      byte_q       <= 8'h00;
      bvld_q       <= 1'b0;
      err_q        <= ERR_NONE;
      evld_q       <= 1'b0;
    end else begin
      sr_q         <= sr_n;
      pend_q       <= pend_n;
      pend_proto_q <= pend_proto_n;
      proto_q      <= proto_n;
      err_hold_q   <= err_hold_n;
      byte_q       <= byte_n;
      bvld_q       <= bvld_n;
      err_q        <= err_n;
      evld_q       <= evld_n;
    end
  end

  assign kb_clk_hold_o = inhibit;
  assign byte_valid_o  = bvld_q;
  assign byte_o        = byte_q;
  assign proto_o       = proto_q;
  assign err_valid_o   = evld_q;
  assign err_code_o    = err_q;

  // ---------------- assertions ----------------
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    kbc_fall |=> !kbc_fall);

  p_marker_kept_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    sr_q != '0);

  p_idle_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    bvld_q |-> (sr_q == SHIFT_IDLE));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bvld_q && evld_q));

  p_err_holds_clk_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    evld_q |-> kb_clk_hold_o);

  p_illegal_clears_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (evld_q && err_q == ERR_ILLEGAL) |-> (proto_q == PROTO_NONE));

  p_timeout_keeps_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (evld_q && err_q == ERR_TIMEOUT) |-> (proto_q == $past(proto_q)));

  p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    buf_full_i |=> (sr_q == SHIFT_IDLE && !bvld_q));

endmodule

// File: tb/test_kbd_frame_rx.sv
module test_kbd_frame_rx;

  localparam int unsigned WAIT_CYC    = 40;
  localparam int unsigned TIMEOUT_CYC = 300;
  localparam int unsigned HALF        = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk = 1'b1;
  logic kb_data = 1'b1;
  logic buf_full = 1'b0;
  logic resume = 1'b0;

  logic       hold, bvld, evld;
  logic [7:0] byte_w;
  logic [2:0] proto_w, err_w;

  kbd_frame_rx #(
    .WAIT_CYC   (WAIT_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(2)
  ) i_kbd_frame_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .kb_clk_i     (kb_clk),
    .kb_data_i    (kb_data),
    .buf_full_i   (buf_full),
    .resume_i     (resume),
    .kb_clk_hold_o(hold),
    .byte_valid_o (bvld),
    .byte_o       (byte_w),
    .proto_o      (proto_w),
    .err_valid_o  (evld),
    .err_code_o   (err_w)
  );

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int n_bytes = 0;
  int n_errs  = 0;
  logic [7:0] last_byte = 8'h00;
  logic [2:0] last_proto = 3'd0;
  logic [2:0] last_err = 3'd0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (bvld) begin
      n_bytes++;
      last_byte  = byte_w;
      last_proto = proto_w;
    end
    if (evld) begin
      n_errs++;
      last_err = err_w;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      kb_data = bits[i];
      kb_clk  = 1'b1;
      tick(HALF);
      kb_clk  = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic send_at(input logic [7:0] v, input logic par, input logic stop);
    send_bits({5'b0, stop, par, v, 1'b0}, 11);
  endtask

  function automatic logic odd_par(input logic [7:0] v);
    return ~^v;
  endfunction

  task automatic pulse_resume();
    resume = 1'b1;
    tick(1);
    resume = 1'b0;
    tick(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    kb_clk = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  // byte expected right after the last edge
  task automatic expect_now(input string req, input int base, input logic [7:0] v, input logic [2:0] p);
    tick(4);
    chk(n_bytes == base + 1, req, n_bytes, base + 1);
    chk(last_byte == v, req, last_byte, v);
    chk(last_proto == p, req, last_proto, p);
  endtask

  // byte expected only after the idle window
  task automatic expect_waited(input string req, input int base, input logic [7:0] v, input logic [2:0] p);
    chk(n_bytes == base, req, n_bytes, base);
    tick(WAIT_CYC + 10);
    chk(n_bytes == base + 1, req, n_bytes, base + 1);
    chk(last_byte == v, req, last_byte, v);
    chk(last_proto == p, req, last_proto, p);
  endtask

  task automatic expect_err(input string req, input int base, input logic [2:0] code);
    tick(4);
    chk(n_errs == base + 1, req, n_errs, base + 1);
    chk(last_err == code, req, last_err, code);
    chk(hold == 1'b1, req, hold, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, e0;

    // ---------- phase A ----------
    do_reset();
    // R1 reset state
    chk(bvld == 1'b0, "R1 byte_valid", bvld, 0);
    chk(evld == 1'b0, "R1 err_valid", evld, 0);
    chk(proto_w == 3'd0, "R1 proto", proto_w, 0);
    chk(hold == 1'b0, "R1 hold", hold, 0);

    // R6 single-start frame, unknown format: waits
    b0 = n_bytes;
    send_bits({7'b0, 8'h5A, 1'b1}, 9);
    expect_waited("R6 clone waited", b0, 8'h5A, 3'd4);
    // R6 format known: immediate
    b0 = n_bytes;
    send_bits({7'b0, 8'h3C, 1'b1}, 9);
    expect_now("R6 clone immediate", b0, 8'h3C, 3'd4);

    // R9/R12 double-start frame under clone format continues, then times out
    b0 = n_bytes; e0 = n_errs;
    send_bits({6'b0, 8'h81, 1'b1, 1'b0}, 10);
    tick(100);
    chk(n_bytes == b0 && n_errs == e0, "R12 no early finish", n_errs, e0);
    tick(TIMEOUT_CYC);
    chk(n_errs == e0 + 1, "R9 timeout count", n_errs, e0 + 1);
    chk(last_err == 3'd4, "R9 timeout code", last_err, 4);
    chk(proto_w == 3'd4, "R9 proto kept", proto_w, 4);
    chk(hold == 1'b1, "R10 hold after timeout", hold, 1);
    pulse_resume();
    chk(hold == 1'b0, "R10 hold released", hold, 0);
    b0 = n_bytes;
    send_bits({7'b0, 8'hC3, 1'b1}, 9);
    expect_now("R10 clean restart", b0, 8'hC3, 3'd4);

    // ---------- phase B ----------
    do_reset();
    chk(proto_w == 3'd0, "R1 proto after reset", proto_w, 0);
    b0 = n_bytes;
    send_bits({6'b0, 8'h6D, 1'b1, 1'b0}, 10);
    expect_waited("R5 ibm waited", b0, 8'h6D, 3'd3);
    b0 = n_bytes;
    send_bits({6'b0, 8'hF1, 1'b1, 1'b0}, 10);
    expect_now("R5 ibm immediate", b0, 8'hF1, 3'd3);

    // R8 illegal: begins 1,0
    e0 = n_errs;
    send_bits({6'b0, 8'h12, 1'b0, 1'b1}, 10);
    expect_err("R8 illegal", e0, 3'd3);
    chk(proto_w == 3'd0, "R8 proto cleared", proto_w, 0);
    // R10 edges ignored while held
    b0 = n_bytes;
    send_at(8'h44, odd_par(8'h44), 1'b1);
    tick(WAIT_CYC + 10);
    chk(n_bytes == b0, "R10 ignored while held", n_bytes, b0);
    chk(hold == 1'b1, "R10 still held", hold, 1);
    pulse_resume();

    // R2 sweep of all bytes
    for (int v = 0; v < 256; v++) begin
      b0 = n_bytes;
      send_at(8'(v), odd_par(8'(v)), 1'b1);
      expect_now("R2 at frame", b0, 8'(v), 3'd1);
    end

    // R3 low stop
    for (int k = 0; k < 4; k++) begin
      b0 = n_bytes;
      send_at(8'(k * 67 + 5), odd_par(8'(k * 67 + 5)), 1'b0);
      expect_now("R3 low stop", b0, 8'(k * 67 + 5), 3'd2);
    end

    // R4 bad parity
    for (int k = 0; k < 4; k++) begin
      e0 = n_errs;
      send_at(8'(k * 53 + 9), ~odd_par(8'(k * 53 + 9)), 1'b1);
      expect_err("R4 parity", e0, 3'd1);
      pulse_resume();
    end
    e0 = n_errs;
    send_at(8'hAA, 1'b0, 1'b1);
    expect_err("R4 aa special", e0, 3'd2);
    pulse_resume();
    e0 = n_errs;
    send_at(8'hAA, 1'b0, 1'b0);
    expect_err("R4 aa low stop plain", e0, 3'd1);
    pulse_resume();

    // R7/R12 begins 1,1 under AT format
    b0 = n_bytes; e0 = n_errs;
    send_bits({6'b0, 8'h9B, 1'b1, 1'b1}, 10);
    expect_now("R7 xt error frame", b0, 8'h9B, 3'd5);
    chk(n_errs == e0, "R7 no error", n_errs, e0);

    // R11 buffer full
    buf_full = 1'b1;
    tick(2);
    chk(hold == 1'b1, "R11 hold on full", hold, 1);
    b0 = n_bytes;
    send_at(8'h55, odd_par(8'h55), 1'b1);
    tick(WAIT_CYC + 10);
    chk(n_bytes == b0, "R11 ignored while full", n_bytes, b0);
    buf_full = 1'b0;
    tick(2);
    chk(hold == 1'b0, "R11 hold released", hold, 0);
    b0 = n_bytes;
    send_at(8'h81, odd_par(8'h81), 1'b1);
    expect_now("R11 after release", b0, 8'h81, 3'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule